// File: doc/BRIEF.md
# Activity-Triggered Array Power-Down Controller

This block decides, cycle by cycle, whether a memory array should be powered. It watches the select, write strobe, address and data inputs of the memory's bus. A qualifying transition wakes the array at once, and the array stays powered for a fixed number of clock cycles after the most recent such transition. Because the array drops back to low power even while select is held active, the power drawn follows how often the bus changes, not how long the memory stays selected.

Every input is compared with its own value from the previous clock. There are four wake events. Select falling to active wakes the array. A write strobe falling to active wakes it only while select is active. Any address change wakes it while select is active. Any data change wakes it only while both select and write strobe are active. When a wake event occurs, a two-state machine (SLEEP, AWAKE) enters or stays in AWAKE and reloads a down-counter.

The machine has five transitions. SLEEP goes to AWAKE on a wake event (wake). AWAKE stays in AWAKE with the counter reloaded on a further event (retrigger). AWAKE stays in AWAKE with the counter decremented while it is non-zero (count). AWAKE goes to SLEEP once the counter is zero and no event arrives (expire). AWAKE goes to SLEEP whenever select is inactive (deselect). The block only produces the power request; the supply switching itself lies outside it.

Top module: `activity_pwrdn_ctrl`

## Requirements
- R1: During synchronous reset and in every cycle after it until the first wake event, `array_on` is 0. The previous-value registers load the inputs during reset, so steady inputs at release cause no wake.
- R2: A 1-to-0 change of `sel_n` between two consecutive clocks raises `array_on` in that same cycle.
- R3: A 1-to-0 change of `wr_n` raises `array_on` in that cycle only if `sel_n` is 0. While `sel_n` is 1 it has no effect.
- R4: Any change of `addr` from the previous clock raises `array_on` in that cycle only if `sel_n` is 0. While deselected it has no effect.
- R5: Any change of `data` from the previous clock raises `array_on` only if `sel_n` and `wr_n` are both 0. During a read (`wr_n` = 1) it has no effect.
- R6: After a wake event in cycle T, with no further event and `sel_n` held at 0, `array_on` is 1 in cycles T through T+TIMEOUT_CYC and 0 in cycle T+TIMEOUT_CYC+1.
- R7: A wake event during the powered window restarts the full window from that event's cycle.
- R8: Whenever `sel_n` is 1, `array_on` is 0 in that same cycle and the remaining window is discarded.
- R9: Holding `sel_n` at 0 with all other inputs steady does not keep the array powered past the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Memory select, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Address bus |
| data | input | DATA_W | Data bus |
| array_on | output | 1 | Array power request, high while the array should be powered |

## Verification
Assertions in the detector and the state machine check on every cycle that:
- a select fall or a selected address change always produces a wake event;
- a read-time data change alone never does;
- a wake event reloads the counter;
- the counter steps down by one;
- a zero count expires into SLEEP;
- deselection forces SLEEP.

Two things need the bench's scenarios instead: the exact length of the powered window as seen at the output, and the effect of mixed, overlapping events. The bench covers these with directed sequences and a long seeded random run, scored against an independent cycle model of the window.

// File: rtl/activity_pwrdn_pkg.sv
package activity_pwrdn_pkg;
    typedef enum logic {
        PWR_SLEEP = 1'b0,
        PWR_AWAKE = 1'b1
    } pwr_state_e;
endpackage

// File: rtl/activity_detect.sv
module activity_detect #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              wake
);
    logic              sel_n_q;
    logic              wr_n_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // previous-cycle copies; loaded during reset too so release is quiet
    always_ff @(posedge clk) begin
        sel_n_q <= sel_n;
        wr_n_q  <= wr_n;
        addr_q  <= addr;
        data_q  <= data;
    end

    logic ev_sel, ev_wr, ev_addr, ev_data;

    always_comb begin
        ev_sel  = sel_n_q & ~sel_n;
        ev_wr   = ~sel_n & wr_n_q & ~wr_n;
        ev_addr = ~sel_n & (addr != addr_q);
        ev_data = ~sel_n & ~wr_n & (data != data_q);
        wake    = ~rst & (ev_sel | ev_wr | ev_addr | ev_data);
    end

    assert_sel_fall_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(sel_n) |-> wake);

    assert_addr_change_R4: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && (addr != $past(addr))) |-> wake);

    assert_read_data_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && wr_n && $stable(sel_n) && $stable(addr)) |-> !wake);

    assert_deselected_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        sel_n |-> !wake);
endmodule

// File: rtl/pwr_window_fsm.sv
module pwr_window_fsm
    import activity_pwrdn_pkg::*;
#(
    parameter int TIMEOUT_CYC = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_n,
    input  logic wake,
    output logic array_on
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT_CYC - 1);

    pwr_state_e    state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            PWR_SLEEP: begin
                if (wake) begin
                    state_nxt = PWR_AWAKE;
                    cnt_nxt   = RELOAD;
                end
            end
            PWR_AWAKE: begin
                if (sel_n) begin
                    state_nxt = PWR_SLEEP;
                    cnt_nxt   = '0;
                end else if (wake) begin
                    cnt_nxt   = RELOAD;
                end else if (cnt == '0) begin
                    state_nxt = PWR_SLEEP;
                end else begin
                    cnt_nxt   = cnt - CW'(1);
                end
            end
            default: begin
                state_nxt = PWR_SLEEP;
                cnt_nxt   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PWR_SLEEP;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // outputs
    always_comb begin
        array_on = ~rst & ~sel_n & (wake | (state == PWR_AWAKE));
    end

    assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
        wake |=> (state == PWR_AWAKE && cnt == RELOAD));

    assert_countdown_R6: assert property (@(posedge clk) disable iff (rst)
        (state == PWR_AWAKE && !wake && !sel_n && cnt != '0)
        |=> (cnt == $past(cnt) - CW'(1)));

    assert_expire_R9: assert property (@(posedge clk) disable iff (rst)
        (state == PWR_AWAKE && !wake && cnt == '0) |=> (state == PWR_SLEEP));

    assert_deselect_R8: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> (state == PWR_SLEEP));
endmodule

// File: rtl/activity_pwrdn_ctrl.sv
module activity_pwrdn_ctrl #(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int TIMEOUT_CYC = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              array_on
);
    logic wake;

    activity_detect #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) detect_i (
        .clk  (clk),
        .rst  (rst),
        .sel_n(sel_n),
        .wr_n (wr_n),
        .addr (addr),
        .data (data),
        .wake (wake)
    );

    pwr_window_fsm #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) fsm_i (
        .clk     (clk),
        .rst     (rst),
        .sel_n   (sel_n),
        .wake    (wake),
        .array_on(array_on)
    );

    assert_reset_off_R1: assert property (@(posedge clk)
        rst |-> !array_on);

    assert_deselect_off_R8: assert property (@(posedge clk) disable iff (rst)
        sel_n |-> !array_on);
endmodule

// File: tb/activity_pwrdn_ctrl_tb_top.sv
`timescale 1ns/1ps
module activity_pwrdn_ctrl_tb_top;
    localparam int AW  = 13;
    localparam int DW  = 8;
    localparam int TO  = 5;
    localparam int BIG = 1000000;

    logic          clk = 1'b0;
    logic          rst;
    logic          sel_n;
    logic          wr_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          array_on;

    always #2 clk = ~clk;

    activity_pwrdn_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .TIMEOUT_CYC(TO)
    ) dut_i (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n),
        .addr(addr), .data(data), .array_on(array_on)
    );

    int n_cmp  = 0;
    int n_bad  = 0;
    int age    = BIG;
    bit done   = 1'b0;
    logic          p_sel, p_wr;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_data;

    function automatic logic model_wake(
        logic ps, logic pw, logic [AW-1:0] pa, logic [DW-1:0] pd,
        logic s, logic w, logic [AW-1:0] a, logic [DW-1:0] d);
        return (ps && !s) || (!s && pw && !w) || (!s && a != pa) ||
               (!s && !w && d != pd);
    endfunction

    function automatic string auto_tag(logic t);
        if (rst)   return "R1";
        if (sel_n) return "R8";
        if (t)     return (age < BIG && age <= TO) ? "R7" : "R2";
        return "R6";
    endfunction

    task automatic tick(input string tag);
        logic t, e;
        string tg;
        #1;
        t  = !rst && model_wake(p_sel, p_wr, p_addr, p_data, sel_n, wr_n, addr, data);
        tg = (tag == "") ? auto_tag(t) : tag;
        if (rst || sel_n) begin
            e = 1'b0; age = BIG;
        end else if (t) begin
            e = 1'b1; age = 0;
        end else begin
            if (age < BIG) age++;
            e = (age <= TO);
        end
        n_cmp++;
        if (array_on !== e) begin
            n_bad++;
            $display("FAIL %s at %0t: array_on=%b expected=%b", tg, $time, array_on, e);
        end
        p_sel = sel_n; p_wr = wr_n; p_addr = addr; p_data = data;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; sel_n = 1'b1; wr_n = 1'b1; addr = 13'h0A5; data = 8'h00;
        @(negedge clk);
        repeat (3) tick("R1");
        rst = 1'b0;
        repeat (2) tick("R1");

        // R3/R4: activity while deselected is ignored
        addr = 13'h1F0; tick("R4");
        wr_n = 1'b0;    tick("R3");
        data = 8'h5A;   tick("R5");
        wr_n = 1'b1;    tick("R3");

        // R2 wake, R6 window, R9 idle selection drops power
        sel_n = 1'b0; tick("R2");
        repeat (TO) tick("R6");
        repeat (3) tick("R9");

        // R3 selected write fall, then R5 data change during write
        wr_n = 1'b0; tick("R3");
        repeat (TO + 2) tick("R6");
        data = data ^ 8'h3C; tick("R5");
        repeat (TO + 2) tick("R6");

        // R5: data change during read is ignored
        wr_n = 1'b1; tick("R5");
        data = data ^ 8'hFF; tick("R5");
        tick("R5");

        // R4 address wake, R7 retrigger mid-window
        addr = addr + 13'd1; tick("R4");
        repeat (3) tick("R6");
        addr = addr ^ 13'h100; tick("R7");
        repeat (TO + 2) tick("R7");

        // R8: deselect cuts power at once, reselect wakes again
        addr = addr + 13'd7; tick("R4");
        sel_n = 1'b1; tick("R8");
        tick("R8");
        sel_n = 1'b0; tick("R2");
        repeat (TO + 2) tick("R6");

        // seeded random traffic
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(99) < 4)  sel_n = ~sel_n;
            if ($urandom_range(99) < 8)  wr_n  = ~wr_n;
            if ($urandom_range(99) < 10) addr  = AW'($urandom);
            if ($urandom_range(99) < 10) data  = DW'($urandom);
            tick("");
        end

        // mid-run reset
        rst = 1'b1; sel_n = 1'b0; addr = addr + 13'd3; tick("R1");
        rst = 1'b0; tick("R1");
        tick("R1");
        finish_run();
    end
endmodule